// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked user request port and an external asynchronous static RAM of 64K locations by 1 bit. That RAM has separate input and output data pins, an active-low select and an active-low write strobe. The user raises a request with a read/write flag, a 16-bit address and, for writes, one data bit. The controller then runs the memory pins through a fixed sequence of phases: select, strobe, hold and recovery. Every pin change is registered, so the pins move only on clock edges.

All memory timing limits are parameters in nanoseconds: cycle time, select and address windows ahead of the end of write, strobe width, data setup, data hold, address setup, write recovery and the two access times. Each limit is turned into a whole number of clocks of the configured period by rounding up. Every access is stretched to meet the slowest of the limits that apply to it. The select line always falls at least one clock before the write strobe, and the write ends on the rising strobe while address and data stay unchanged. A read samples the memory's data output only after the access window has fully passed.

While an access is in flight the block reports busy and ignores new requests. It ends every access with a single-cycle done pulse. For a read, the captured bit stays on the read-data output until the next read completes.

Top module: `sramc_top`

## Requirements
- R1: After reset the memory select and write strobe are both high (inactive), busy is low and done is low.
- R2: The write strobe is low only while the select is low, and the select has already been low for at least one clock when the strobe falls.
- R3: While select and strobe are both low, neither the memory address nor the memory write data changes.
- R4: The strobe-low window of a write is at least the strobe width. The time from select low to the end of write is at least the select and address windows. Write data is stable for at least the data setup time before the end of write.
- R5: Address and write data stay unchanged for at least one clock after the strobe rises, which covers the data hold and write recovery times.
- R6: The memory data output is captured no earlier than the larger access time after the address and select last changed. The captured value stays on rdata until the next read completes, and writes leave it unchanged.
- R7: Select returns high for at least two clocks between consecutive accesses, and each access lasts at least the applicable cycle time.
- R8: busy is high from the clock after a request is accepted until done. done is a one-clock pulse and is high only when busy is low.
- R9: A request raised while busy is ignored: it changes neither the memory address nor the stored data, and it produces no extra done pulse.
- R10: A read of an address returns the bit most recently written there. An address never written reads as 0 in the bench's memory model.
- R11: Phase lengths in clocks use ceil(ns / CLK_NS), with any phase that must exist taking at least one clock. The phases are:
  - setup: max(1, ceil(AS));
  - strobe: max(1, ceil(WP), ceil(DW), ceil(CW) - setup, ceil(AW) - setup);
  - hold: max(1, ceil(max(DH, WR)));
  - write recovery: max(1, ceil(WC) - setup - strobe - hold);
  - access: max(1, ceil(max(AA, ACS)) - setup);
  - read recovery: max(1, ceil(RC) - setup - access).

  The request-to-done latency is the sum of the access's phases plus one clock; with the defaults this is 7 clocks for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, period CLK_NS |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 1 | Bit to write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock pulse at the end of each access |
| rdata | output | 1 | Bit captured by the last read |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_din | output | 1 | Data to the memory input pin |
| mem_dout | input | 1 | Data from the memory output pin |

## Verification
On every cycle, the embedded assertions check the pin ordering rules: the strobe only inside select, select leading the strobe, and address and data frozen inside and just after the strobe. They also check the single-cycle done pulse, the address freeze while busy, the select gap, and that the phase timer is only reloaded when a phase ends. The absolute nanosecond windows can only be shown by the bench's memory model, which measures them in clocks: strobe width, select-to-end, data setup, and whether a read sampled a settled output. The same holds for data correctness across random and directed accesses, the exact request-to-done latency, and ignoring requests raised mid-access.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RWAIT,
        ST_RECOVER
    } sramc_state_e;

    // Round a nanosecond limit up to whole clocks; zero stays zero.
    function automatic int ns_to_clk(input int t_ns, input int clk_ns);
        if (t_ns <= 0) return 0;
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
`timescale 1ns/1ps
module sramc_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             last
);

    logic [CNT_W-1:0] rem_d, rem_q;

    always_comb begin
        if (load) begin
            rem_d = len;
        end else if (rem_q != '0) begin
            rem_d = rem_q - 1'b1;
        end else begin
            rem_d = rem_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else begin
            rem_q <= rem_d;
        end
    end

    assign last = (rem_q == {{(CNT_W-1){1'b0}}, 1'b1});

    // R11: every phase that is started lasts at least one clock
    a_r11_nonzero_phase: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len != '0));

    // R11: a new phase is never started while the running one has clocks left
    a_r11_no_midphase_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (rem_q <= {{(CNT_W-1){1'b0}}, 1'b1}));

endmodule

// File: rtl/sramc_seq.sv
`timescale 1ns/1ps
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 8,
    parameter int N_SETUP = 1,
    parameter int N_PULSE = 3,
    parameter int N_HOLD  = 1,
    parameter int N_WREC  = 1,
    parameter int N_ACC   = 4,
    parameter int N_RREC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    input  logic              tmr_last,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_len,
    output logic              busy,
    output logic              done,
    output logic              rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_din,
    input  logic              mem_dout
);

    localparam logic [CNT_W-1:0] LEN_SETUP = CNT_W'(N_SETUP);
    localparam logic [CNT_W-1:0] LEN_PULSE = CNT_W'(N_PULSE);
    localparam logic [CNT_W-1:0] LEN_HOLD  = CNT_W'(N_HOLD);
    localparam logic [CNT_W-1:0] LEN_WREC  = CNT_W'(N_WREC);
    localparam logic [CNT_W-1:0] LEN_ACC   = CNT_W'(N_ACC);
    localparam logic [CNT_W-1:0] LEN_RREC  = CNT_W'(N_RREC);

    typedef struct packed {
        sramc_state_e      st;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic              wdata;
        logic              cs_n;
        logic              we_n;
        logic              rdata;
        logic              done;
    } seq_state_t;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_len  = '0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req) begin
                    s_d.st    = ST_SETUP;
                    s_d.is_wr = req_write;
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                    s_d.cs_n  = 1'b0;
                    s_d.we_n  = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_len   = LEN_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_last) begin
                    tmr_load = 1'b1;
                    if (s_q.is_wr) begin
                        s_d.st   = ST_WPULSE;
                        s_d.we_n = 1'b0;
                        tmr_len  = LEN_PULSE;
                    end else begin
                        s_d.st  = ST_RWAIT;
                        tmr_len = LEN_ACC;
                    end
                end
            end
            ST_WPULSE: begin
                if (tmr_last) begin
                    s_d.st   = ST_WHOLD;
                    s_d.we_n = 1'b1;
                    s_d.cs_n = 1'b1;
                    tmr_load = 1'b1;
                    tmr_len  = LEN_HOLD;
                end
            end
            ST_WHOLD: begin
                if (tmr_last) begin
                    s_d.st   = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_len  = LEN_WREC;
                end
            end
            ST_RWAIT: begin
                if (tmr_last) begin
                    s_d.st    = ST_RECOVER;
                    s_d.rdata = mem_dout;
                    s_d.cs_n  = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_len   = LEN_RREC;
                end
            end
            ST_RECOVER: begin
                if (tmr_last) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st    <= ST_IDLE;
            s_q.is_wr <= 1'b0;
            s_q.addr  <= '0;
            s_q.wdata <= 1'b0;
            s_q.cs_n  <= 1'b1;
            s_q.we_n  <= 1'b1;
            s_q.rdata <= 1'b0;
            s_q.done  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.st != ST_IDLE);
    assign done     = s_q.done;
    assign rdata    = s_q.rdata;
    assign mem_addr = s_q.addr;
    assign mem_cs_n = s_q.cs_n;
    assign mem_we_n = s_q.we_n;
    assign mem_din  = s_q.wdata;

    // R2: strobe low only inside select low
    a_r2_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && mem_cs_n));

    // R2: select already low for a clock when the strobe falls
    a_r2_cs_leads_we: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (!mem_cs_n && $past(!mem_cs_n)));

    // R3: address and data frozen while both strobes are low
    a_r3_frozen_in_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !mem_we_n) |=>
            (mem_cs_n || mem_we_n || ($stable(mem_addr) && $stable(mem_din))));

    // R5: address and data held for a clock after the end of write
    a_r5_hold_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> ($stable(mem_addr) && $stable(mem_din)));

    // R7: select stays high for a second clock once released
    a_r7_select_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) |=> mem_cs_n);

    // R8: done is a single clock and only while idle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: nothing reloads the address while an access runs
    a_r9_busy_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mem_addr));

endmodule

// File: rtl/sramc_top.sv
`timescale 1ns/1ps
module sramc_top
    import sramc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int CLK_NS = 20,
    parameter int T_RC   = 85,
    parameter int T_AA   = 85,
    parameter int T_ACS  = 85,
    parameter int T_WC   = 85,
    parameter int T_CW   = 65,
    parameter int T_AW   = 65,
    parameter int T_WP   = 45,
    parameter int T_AS   = 0,
    parameter int T_WR   = 0,
    parameter int T_DW   = 35,
    parameter int T_DH   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    output logic              busy,
    output logic              done,
    output logic              rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_din,
    input  logic              mem_dout
);

    localparam int C_RC  = ns_to_clk(T_RC, CLK_NS);
    localparam int C_WC  = ns_to_clk(T_WC, CLK_NS);
    localparam int C_CW  = ns_to_clk(T_CW, CLK_NS);
    localparam int C_AW  = ns_to_clk(T_AW, CLK_NS);
    localparam int C_WP  = ns_to_clk(T_WP, CLK_NS);
    localparam int C_AS  = ns_to_clk(T_AS, CLK_NS);
    localparam int C_DW  = ns_to_clk(T_DW, CLK_NS);
    localparam int C_HLD = ns_to_clk(imax(T_DH, T_WR), CLK_NS);
    localparam int C_ACC = ns_to_clk(imax(T_AA, T_ACS), CLK_NS);

    localparam int N_SETUP = imax(1, C_AS);
    localparam int N_PULSE = imax(1, imax(imax(C_WP, C_DW),
                                          imax(C_CW - N_SETUP, C_AW - N_SETUP)));
    localparam int N_HOLD  = imax(1, C_HLD);
    localparam int N_WREC  = imax(1, C_WC - (N_SETUP + N_PULSE + N_HOLD));
    localparam int N_ACC   = imax(1, C_ACC - N_SETUP);
    localparam int N_RREC  = imax(1, C_RC - (N_SETUP + N_ACC));

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_last;

    sramc_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .last  (tmr_last)
    );

    sramc_seq #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .N_SETUP (N_SETUP),
        .N_PULSE (N_PULSE),
        .N_HOLD  (N_HOLD),
        .N_WREC  (N_WREC),
        .N_ACC   (N_ACC),
        .N_RREC  (N_RREC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .tmr_last  (tmr_last),
        .tmr_load  (tmr_load),
        .tmr_len   (tmr_len),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .mem_addr  (mem_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_we_n  (mem_we_n),
        .mem_din   (mem_din),
        .mem_dout  (mem_dout)
    );

endmodule

// File: tb/sramc_top_tb.sv
`timescale 1ns/1ps
module sramc_top_tb;

    localparam int CLK_NS = 20;
    localparam int T_RC = 85, T_AA = 85, T_ACS = 85, T_WC = 85, T_CW = 65;
    localparam int T_AW = 65, T_WP = 45, T_AS = 0, T_WR = 0, T_DW = 35, T_DH = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
    logic [15:0] req_addr = '0;
    logic        busy, done, rdata;
    logic [15:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_din;
    logic        mem_dout = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sramc_top u_dut (
        .clk (clk), .rst_n (rst_n), .req (req), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata), .busy (busy), .done (done),
        .rdata (rdata), .mem_addr (mem_addr), .mem_cs_n (mem_cs_n),
        .mem_we_n (mem_we_n), .mem_din (mem_din), .mem_dout (mem_dout)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural memory with timing monitors ----------------
    bit model_mem [int unsigned];
    bit ref_mem   [int unsigned];

    function automatic bit mget(input int unsigned a);
        return model_mem.exists(a) ? model_mem[a] : 1'b0;
    endfunction
    function automatic bit rget(input int unsigned a);
        return ref_mem.exists(a) ? ref_mem[a] : 1'b0;
    endfunction
    function automatic int cdiv(input int t);
        return (t <= 0) ? 0 : (t + CLK_NS - 1) / CLK_NS;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // R11 latency derivation, from the requirement text
    function automatic int exp_latency(input bit wr);
        int su, pw, hd, rc, ac;
        su = mx(1, cdiv(T_AS));
        if (wr) begin
            pw = mx(1, mx(mx(cdiv(T_WP), cdiv(T_DW)), mx(cdiv(T_CW) - su, cdiv(T_AW) - su)));
            hd = mx(1, cdiv(mx(T_DH, T_WR)));
            rc = mx(1, cdiv(T_WC) - su - pw - hd);
            return su + pw + hd + rc + 1;
        end
        ac = mx(1, cdiv(mx(T_AA, T_ACS)) - su);
        rc = mx(1, cdiv(T_RC) - su - ac);
        return su + ac + rc + 1;
    endfunction

    logic [15:0] p_addr;
    logic        p_cs, p_we, p_din;
    int ovl_cnt, csl_cnt, din_cnt, adr_cnt, rd_cnt;

    always @(negedge clk) begin
        bit ovl, p_ovl;
        if (!rst_n) begin
            p_addr = mem_addr; p_cs = 1'b1; p_we = 1'b1; p_din = mem_din;
            ovl_cnt = 0; csl_cnt = 0; din_cnt = 0; adr_cnt = 0; rd_cnt = 0;
        end else begin
            ovl   = !mem_cs_n && !mem_we_n;
            p_ovl = !p_cs && !p_we;
            if (!mem_we_n && mem_cs_n) chk(0, "R2 strobe outside select", 1, 0);
            if (!mem_we_n && p_we && p_cs) chk(0, "R2 select not leading strobe", 0, 1);
            if (mem_addr != p_addr && (ovl || p_ovl))
                chk(0, "R3 address moved in overlap", int'(mem_addr), int'(p_addr));
            if (ovl && p_ovl && mem_din != p_din)
                chk(0, "R3 data moved in overlap", int'(mem_din), int'(p_din));
            if (p_ovl && !ovl) begin
                chk(ovl_cnt * CLK_NS >= T_WP, "R4 strobe width ns", ovl_cnt * CLK_NS, T_WP);
                chk(csl_cnt * CLK_NS >= T_CW, "R4 select to end ns", csl_cnt * CLK_NS, T_CW);
                chk(adr_cnt * CLK_NS >= T_AW, "R4 address to end ns", adr_cnt * CLK_NS, T_AW);
                chk(din_cnt * CLK_NS >= T_DW, "R4 data setup ns", din_cnt * CLK_NS, T_DW);
                chk(mem_addr == p_addr && mem_din == p_din, "R5 hold after write",
                    int'(mem_addr), int'(p_addr));
                model_mem[int'(p_addr)] = p_din;
            end
            ovl_cnt = ovl ? ovl_cnt + 1 : 0;
            csl_cnt = mem_cs_n ? 0 : csl_cnt + 1;
            din_cnt = (mem_din == p_din) ? din_cnt + 1 : 1;
            adr_cnt = (mem_addr == p_addr) ? adr_cnt + 1 : 1;
            rd_cnt  = (mem_addr != p_addr || (!mem_cs_n && p_cs)) ? 0 : rd_cnt + 1;
            // settled output only once the access window has elapsed at the next edge
            if (!mem_cs_n && mem_we_n && (rd_cnt + 1) * CLK_NS >= mx(T_AA, T_ACS))
                mem_dout = mget(int'(mem_addr));
            else
                mem_dout = ~mget(int'(mem_addr));
            p_addr = mem_addr; p_cs = mem_cs_n; p_we = mem_we_n; p_din = mem_din;
        end
    end

    // ---------------- access task ----------------
    task automatic access(input bit wr, input logic [15:0] a, input bit d, output int lat);
        @(negedge clk);
        req = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        if (wr) ref_mem[int'(a)] = d;
        @(negedge clk);
        chk(done == 1'b0, "R8 done single pulse", int'(done), 0);
    endtask

    task automatic do_write(input logic [15:0] a, input bit d);
        int lat;
        access(1'b1, a, d, lat);
        chk(lat == exp_latency(1'b1), "R7 R11 write latency", lat, exp_latency(1'b1));
    endtask

    task automatic do_read_check(input logic [15:0] a);
        int lat;
        bit e;
        e = rget(int'(a));
        access(1'b0, a, 1'b0, lat);
        chk(lat == exp_latency(1'b0), "R7 R11 read latency", lat, exp_latency(1'b0));
        chk(rdata == e, "R10 R6 read data", int'(rdata), int'(e));
    endtask

    // ---------------- main sequence ----------------
    initial begin
        logic [15:0] pool [16];
        int dn;
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        // R1: reset state while held and just after release
        chk(mem_cs_n == 1'b1 && mem_we_n == 1'b1, "R1 strobes idle", int'({mem_cs_n, mem_we_n}), 3);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done low", int'({busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs_n == 1'b1 && busy == 1'b0, "R1 idle after release", int'({mem_cs_n, busy}), 2);

        // R10: unwritten address and boundaries
        do_read_check(16'h0042);
        do_write(16'h0000, 1'b1);
        do_write(16'hFFFF, 1'b1);
        do_read_check(16'h0000);
        do_read_check(16'hFFFF);
        do_write(16'hFFFF, 1'b0);
        do_read_check(16'hFFFF);

        // R6: rdata held across idle time and across a write
        do_read_check(16'h0000);
        repeat (5) @(negedge clk);
        chk(rdata == 1'b1, "R6 rdata held idle", int'(rdata), 1);
        do_write(16'h0100, 1'b0);
        chk(rdata == 1'b1, "R6 rdata held over write", int'(rdata), 1);

        // R9: request raised mid-access is ignored
        do_write(16'h1234, 1'b1);
        @(negedge clk);
        req = 1'b1; req_write = 1'b1; req_addr = 16'h1234; req_wdata = 1'b1;
        @(negedge clk);
        req_addr = 16'h5555; req_wdata = 1'b0;
        dn = 0;
        repeat (3) begin
            @(negedge clk);
            chk(mem_addr == 16'h1234, "R9 address frozen while busy", int'(mem_addr), 16'h1234);
        end
        req = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (done) dn++;
        end
        chk(dn == 1, "R9 one done for one accepted request", dn, 1);
        do_read_check(16'h5555);
        do_read_check(16'h1234);

        // random mix over a small address pool
        foreach (pool[i]) pool[i] = 16'($urandom);
        for (int k = 0; k < 200; k++) begin
            logic [15:0] a;
            a = pool[$urandom % 16];
            if ($urandom % 2) do_write(a, 1'($urandom));
            else do_read_check(a);
        end
        // write immediately followed by read of the same location
        for (int k = 0; k < 8; k++) begin
            do_write(pool[k], 1'(k));
            do_read_check(pool[k]);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule